// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a chain of transmit descriptors in memory through a one-word read/write port. Each descriptor is four 32-bit words: flags, buffer start address, status with the frame length in its low half, and the address of the next descriptor. When the engine owns a descriptor it reads all four words and hands the buffer address and the frame length to a downstream sender. The length is padded up to a minimum when the descriptor asks for it. After the sender finishes, the engine writes the flags and status words back, returns ownership, and moves on to the next descriptor. It keeps going until it finds a descriptor still held by the CPU. It then halts and waits for the next poll.

Software arms the engine by raising the transmit enable. This loads the working pointer from the list start register but starts no traffic. Each later poll pulse, given while enable is held, starts a pass. Three sticky events are kept with their own enable mask: frame done, no descriptor available, and bus error. These drive a single interrupt line. Dropping the enable stops the engine and latches a halted flag.

Top module: `txd_ring_engine`

## Requirements
- R1: After reset, cur_desc and cur_buf are 0, ev_pend is 0, tx_halted and tx_irq are 0, and no memory request is made. The list start register resets to 0xFFFFFFFC.
- R2: A rising edge of tx_en copies the list start register into cur_desc and issues no memory access. A poll pulse starts processing only while tx_en is high and was high in the previous cycle. A poll while tx_en is low is ignored. No memory request or frame is presented in a cycle that follows one with tx_en low.
- R3: Descriptor words sit at byte offsets +0 (flags), +4 (buffer address), +8 (status/length, length in bits 15:0) and +12 (next address). In the flags word, bit 31 = 1 means the engine owns it, bit 0 is pad enable, and bit 2 is interrupt enable. A memory request holds its address and direction until acknowledged.
- R4: If a fetched flags word has bit 31 clear, the engine halts and sets the unavailable event (ev_pend bit 1). It writes nothing back, and cur_desc keeps that descriptor's address.
- R5: For an owned descriptor, frm_addr is the buffer address. frm_len is 60 when pad enable is set and the length is below 60; otherwise it is the length. frm_padded marks the padded case. Both values are held until frm_done.
- R6: On write-back, the flags word is written with bit 31 cleared and its other bits kept. The status word is written with bits 31:16 cleared except for two bits: bit 19 (done) is set when the sender reported no error, and bit 16 is set when the combined interrupt is active after this descriptor's own events.
- R7: The done event (ev_pend bit 0) is set for a completed frame only if that descriptor's interrupt-enable flag is set.
- R8: After the status write, cur_desc takes the next-descriptor address, and the engine fetches that descriptor without a new poll.
- R9: cur_buf shows the buffer address of the descriptor being, or last, processed.
- R10: A memory error on any descriptor read sets the bus-error event (ev_pend bit 2) and halts the engine. Nothing is written back, and cur_desc is unchanged.
- R11: An error reported by the sender sets the bus-error event without the done event. The descriptor is still written back with ownership returned and done clear, and the engine advances.
- R12: A falling edge of tx_en sets tx_halted, and a halt_clr pulse clears it. If both happen in the same cycle, the flag is set.
- R13: An ev_clr pulse clears the matching ev_pend bits. tx_irq is high exactly when some ev_pend bit and its ev_en bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable level |
| poll | input | 1 | Poll pulse that starts a pass |
| base_we | input | 1 | Write strobe for the list start register |
| base_wdata | input | AW | New list start address |
| halt_clr | input | 1 | Clears the halted flag |
| ev_en | input | 3 | Per-event interrupt enables |
| ev_clr | input | 3 | Per-event clear pulses |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word byte address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted and completed |
| mem_err | input | 1 | Access failed (valid with mem_ack) |
| mem_rdata | input | DW | Read data (valid with mem_ack) |
| frm_valid | output | 1 | Frame handed to the sender |
| frm_addr | output | AW | Frame buffer address |
| frm_len | output | LW | Length to send after padding |
| frm_padded | output | 1 | Length was raised to the minimum |
| frm_done | input | 1 | Sender finished the frame |
| frm_err | input | 1 | Sender hit a buffer read error (with frm_done) |
| cur_desc | output | AW | Current descriptor address |
| cur_buf | output | AW | Current buffer address |
| tx_halted | output | 1 | Transmit halted flag |
| ev_pend | output | 3 | Pending events: 0 done, 1 unavailable, 2 bus error |
| tx_irq | output | 1 | Combined transmit interrupt |

## Verification
The hardest cases to reach from the ports are the two error paths. In one, a descriptor read fails and must leave no write-back. In the other, a buffer read fails yet must still return ownership and advance. The bench's memory model and sender model each hold a set of failing addresses, so chosen descriptors or buffers fail on the exact access that reaches them. The interrupt bit in the status word depends on events left pending by earlier descriptors. The stimulus therefore clears the events and changes the enable mask between passes, so that this bit is seen both set and clear.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int OWN_BIT  = 31;
  localparam int PAD_BIT  = 0;
  localparam int IEN_BIT  = 2;
  localparam int DONE_BIT = 19;
  localparam int INTR_BIT = 16;

  localparam int EV_DONE = 0;
  localparam int EV_UNAV = 1;
  localparam int EV_BERR = 2;
  localparam int N_EV    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FLAGS,
    ST_RD_BUF,
    ST_RD_LEN,
    ST_RD_NEXT,
    ST_SEND,
    ST_WR_FLAGS,
    ST_WR_STAT
  } txd_state_e;

  function automatic logic [1:0] word_sel(txd_state_e s);
    case (s)
      ST_RD_BUF:               return 2'd1;
      ST_RD_LEN, ST_WR_STAT:   return 2'd2;
      ST_RD_NEXT:              return 2'd3;
      default:                 return 2'd0;
    endcase
  endfunction

  function automatic logic is_read(txd_state_e s);
    return (s == ST_RD_FLAGS) || (s == ST_RD_BUF) ||
           (s == ST_RD_LEN)   || (s == ST_RD_NEXT);
  endfunction

  function automatic logic is_write(txd_state_e s);
    return (s == ST_WR_FLAGS) || (s == ST_WR_STAT);
  endfunction

endpackage

// File: rtl/txd_fsm.sv
module txd_fsm
  import txd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       abort,
  input  logic       acc_done,
  input  logic       acc_err,
  input  logic       owned,
  input  logic       frm_done,
  output txd_state_e state
);

  txd_state_e nxt;

  always_comb begin
    nxt = state;
    if (abort) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:     if (start) nxt = ST_RD_FLAGS;
        ST_RD_FLAGS: if (acc_done) nxt = (acc_err || !owned) ? ST_IDLE : ST_RD_BUF;
        ST_RD_BUF:   if (acc_done) nxt = acc_err ? ST_IDLE : ST_RD_LEN;
        ST_RD_LEN:   if (acc_done) nxt = acc_err ? ST_IDLE : ST_RD_NEXT;
        ST_RD_NEXT:  if (acc_done) nxt = acc_err ? ST_IDLE : ST_SEND;
        ST_SEND:     if (frm_done) nxt = ST_WR_FLAGS;
        ST_WR_FLAGS: if (acc_done) nxt = ST_WR_STAT;
        ST_WR_STAT:  if (acc_done) nxt = ST_RD_FLAGS;
        default:     nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

endmodule

// File: rtl/txd_desc.sv
module txd_desc
  import txd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int LW      = 16,
  parameter int MIN_LEN = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rdata,
  input  logic          cap_flags,
  input  logic          cap_len,
  input  logic          cap_next,
  input  logic          cap_stat,
  input  logic          stat_ok,
  input  logic          stat_intr,
  output logic          ien,
  output logic [AW-1:0] next_addr,
  output logic [LW-1:0] frm_len,
  output logic          frm_padded,
  output logic [DW-1:0] wb_flags,
  output logic [DW-1:0] wb_stat
);

  localparam logic [LW-1:0] MIN_L = LW'(MIN_LEN);

  logic [DW-1:0] flags_q;
  logic [LW-1:0] len_q;
  logic [AW-1:0] next_q;
  logic [DW-1:0] stat_q;
  logic [DW-1:0] stat_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      len_q   <= '0;
      next_q  <= '0;
      stat_q  <= '0;
    end else begin
      if (cap_flags) flags_q <= rdata;
      if (cap_len)   len_q   <= rdata[LW-1:0];
      if (cap_next)  next_q  <= rdata[AW-1:0];
      if (cap_stat)  stat_q  <= stat_new;
    end
  end

  always_comb begin
    stat_new            = '0;
    stat_new[LW-1:0]    = len_q;
    stat_new[DONE_BIT]  = stat_ok;
    stat_new[INTR_BIT]  = stat_intr;
  end

  always_comb begin
    frm_padded = flags_q[PAD_BIT] && (len_q < MIN_L);
    frm_len    = frm_padded ? MIN_L : len_q;
    wb_flags   = flags_q;
    wb_flags[OWN_BIT] = 1'b0;
  end

  assign ien       = flags_q[IEN_BIT];
  assign next_addr = next_q;
  assign wb_stat   = stat_q;

endmodule

// File: rtl/txd_events.sv
module txd_events #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] pend,
  output logic         irq
);

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | set;
  end

  assign irq = |(pend & en);

endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
  import txd_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          LW         = 16,
  parameter int          MIN_LEN    = 60,
  parameter logic [31:0] LIST_RESET = 32'hFFFF_FFFC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_en,
  input  logic            poll,
  input  logic            base_we,
  input  logic [AW-1:0]   base_wdata,
  input  logic            halt_clr,
  input  logic [N_EV-1:0] ev_en,
  input  logic [N_EV-1:0] ev_clr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [DW-1:0]   mem_rdata,
  output logic            frm_valid,
  output logic [AW-1:0]   frm_addr,
  output logic [LW-1:0]   frm_len,
  output logic            frm_padded,
  input  logic            frm_done,
  input  logic            frm_err,
  output logic [AW-1:0]   cur_desc,
  output logic [AW-1:0]   cur_buf,
  output logic            tx_halted,
  output logic [N_EV-1:0] ev_pend,
  output logic            tx_irq
);

  localparam int OFF_SHIFT = $clog2(DW / 8);

  txd_state_e      state;
  logic            tx_en_q;
  logic [AW-1:0]   list_base;
  logic [AW-1:0]   cur_desc_q;
  logic [AW-1:0]   cur_buf_q;
  logic            halted_q;
  logic            en_rise, en_fall, start, acc_done;
  logic            rd_ok, send_end;
  logic            ien;
  logic [AW-1:0]   next_addr;
  logic [DW-1:0]   wb_flags, wb_stat;
  logic [N_EV-1:0] ev_set;

  assign en_rise  = tx_en & ~tx_en_q;
  assign en_fall  = ~tx_en & tx_en_q;
  assign start    = poll & tx_en & tx_en_q;
  assign acc_done = mem_req & mem_ack;
  assign rd_ok    = acc_done & ~mem_err & tx_en;
  assign send_end = (state == ST_SEND) & frm_done & tx_en;

  txd_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .abort    (~tx_en),
    .acc_done (acc_done),
    .acc_err  (mem_err),
    .owned    (mem_rdata[OWN_BIT]),
    .frm_done (frm_done),
    .state    (state)
  );

  always_comb begin
    ev_set = '0;
    if (tx_en) begin
      ev_set[EV_UNAV] = (state == ST_RD_FLAGS) & acc_done & ~mem_err & ~mem_rdata[OWN_BIT];
      ev_set[EV_BERR] = (is_read(state) & acc_done & mem_err) | (send_end & frm_err);
      ev_set[EV_DONE] = send_end & ~frm_err & ien;
    end
  end

  txd_desc #(
    .AW(AW), .DW(DW), .LW(LW), .MIN_LEN(MIN_LEN)
  ) u_desc (
    .clk        (clk),
    .rst        (rst),
    .rdata      (mem_rdata),
    .cap_flags  ((state == ST_RD_FLAGS) & rd_ok),
    .cap_len    ((state == ST_RD_LEN) & rd_ok),
    .cap_next   ((state == ST_RD_NEXT) & rd_ok),
    .cap_stat   (send_end),
    .stat_ok    (~frm_err),
    .stat_intr  (|((ev_pend | ev_set) & ev_en)),
    .ien        (ien),
    .next_addr  (next_addr),
    .frm_len    (frm_len),
    .frm_padded (frm_padded),
    .wb_flags   (wb_flags),
    .wb_stat    (wb_stat)
  );

  txd_events #(.N(N_EV)) u_ev (
    .clk  (clk),
    .rst  (rst),
    .set  (ev_set),
    .clr  (ev_clr),
    .en   (ev_en),
    .pend (ev_pend),
    .irq  (tx_irq)
  );

  always_ff @(posedge clk) begin
    tx_en_q <= tx_en;
    if (rst) begin
      list_base  <= LIST_RESET[AW-1:0];
      cur_desc_q <= '0;
      cur_buf_q  <= '0;
      halted_q   <= 1'b0;
    end else begin
      if (base_we) list_base <= base_wdata;
      if (en_rise)
        cur_desc_q <= list_base;
      else if ((state == ST_WR_STAT) && acc_done && tx_en)
        cur_desc_q <= next_addr;
      if ((state == ST_RD_BUF) && rd_ok)
        cur_buf_q <= mem_rdata[AW-1:0];
      if (en_fall)       halted_q <= 1'b1;
      else if (halt_clr) halted_q <= 1'b0;
    end
  end

  assign mem_req   = is_read(state) | is_write(state);
  assign mem_we    = is_write(state);
  assign mem_addr  = cur_desc_q + (AW'(word_sel(state)) << OFF_SHIFT);
  assign mem_wdata = (state == ST_WR_FLAGS) ? wb_flags : wb_stat;
  assign frm_valid = (state == ST_SEND);
  assign frm_addr  = cur_buf_q;
  assign cur_desc  = cur_desc_q;
  assign cur_buf   = cur_buf_q;
  assign tx_halted = halted_q;

endmodule

// File: rtl/txd_ring_chk.sv
module txd_ring_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_en,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          frm_valid,
  input logic [AW-1:0] frm_addr,
  input logic [LW-1:0] frm_len,
  input logic          frm_done,
  input logic          tx_halted
);

  localparam int OFF = $clog2(DW / 8);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mem_req);

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !$past(tx_en) |-> (!mem_req && !frm_valid));

  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && tx_en) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r5_frame_hold: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_done && tx_en) |=> (frm_valid && $stable(frm_addr) && $stable(frm_len)));

  a_r6_owner_returned: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && (mem_addr[OFF+1:OFF] == 2'd0)) |-> !mem_wdata[31]);

  a_r12_halt_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |=> tx_halted);

endmodule

bind txd_ring_engine txd_ring_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_en     (tx_en),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .frm_valid (frm_valid),
  .frm_addr  (frm_addr),
  .frm_len   (frm_len),
  .frm_done  (frm_done),
  .tx_halted (tx_halted)
);

// File: tb/sim_txd_ring_engine.sv
module sim_txd_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] PAD  = 32'h0000_0001;
  localparam logic [31:0] IEN  = 32'h0000_0004;
  localparam logic [31:0] DONE = 32'h0008_0000;
  localparam logic [31:0] INTR = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, poll = 1'b0, base_we = 1'b0, halt_clr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic [2:0]  ev_en = '0, ev_clr = '0;
  logic mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic frm_valid, frm_padded, frm_done = 1'b0, frm_err = 1'b0;
  logic [31:0] frm_addr, cur_desc, cur_buf;
  logic [15:0] frm_len;
  logic tx_halted, tx_irq;
  logic [2:0] ev_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_ring_engine u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .poll(poll), .base_we(base_we),
    .base_wdata(base_wdata), .halt_clr(halt_clr), .ev_en(ev_en), .ev_clr(ev_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .frm_valid(frm_valid), .frm_addr(frm_addr), .frm_len(frm_len),
    .frm_padded(frm_padded), .frm_done(frm_done), .frm_err(frm_err),
    .cur_desc(cur_desc), .cur_buf(cur_buf), .tx_halted(tx_halted),
    .ev_pend(ev_pend), .tx_irq(tx_irq)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [31:0] mem [int unsigned];
  bit err_addr [int unsigned];
  bit buf_err [int unsigned];
  int wr_count = 0, rd_count = 0;
  logic [31:0] got_addr[$];
  int          got_len[$];
  bit          got_pad[$];
  bit ack_prev = 0;
  int snd_cnt = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory and sender models, driven away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 0; mem_err = 0; ack_prev = 0;
      frm_done = 0; frm_err = 0; snd_cnt = 0;
    end else begin
      mem_ack = 0; mem_err = 0;
      if (mem_req && !ack_prev) begin
        mem_ack = 1;
        mem_err = err_addr.exists(mem_addr);
        if (mem_we) begin
          wr_count++;
          if (!mem_err) mem[mem_addr] = mem_wdata;
        end else begin
          rd_count++;
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end
      end
      ack_prev = mem_ack;
      frm_done = 0; frm_err = 0;
      if (frm_valid) begin
        if (snd_cnt == 2) begin
          frm_done = 1;
          frm_err = buf_err.exists(frm_addr);
          got_addr.push_back(frm_addr);
          got_len.push_back(int'(frm_len));
          got_pad.push_back(frm_padded);
          snd_cnt = 0;
        end else snd_cnt++;
      end else snd_cnt = 0;
    end
  end

  // per-clock reference of the halted flag, interrupt line and quiet rule
  bit exp_halted = 0;
  bit en_prev = 0;
  always @(posedge clk) begin
    bit en_now;
    en_now = tx_en;
    if (rst) exp_halted = 0;
    else if (en_prev && !en_now) exp_halted = 1;
    else if (halt_clr) exp_halted = 0;
    #2;
    if (!rst) begin
      check("R12 halted flag", {31'b0, tx_halted}, {31'b0, exp_halted});
      check("R13 irq line", {31'b0, tx_irq}, {31'b0, |(ev_pend & ev_en)});
      if (!en_now) check("R2 quiet while off", {31'b0, mem_req | frm_valid}, 32'h0);
    end
    en_prev = en_now;
  end

  task automatic put_desc(logic [31:0] a, logic [31:0] fl, logic [31:0] b,
                          logic [31:0] lw, logic [31:0] nx);
    mem[a] = fl; mem[a+4] = b; mem[a+8] = lw; mem[a+12] = nx;
  endtask

  task automatic do_poll(int n);
    poll = 1; @(negedge clk); poll = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_events();
    ev_clr = 3'b111; @(negedge clk); ev_clr = 3'b000; @(negedge clk);
  endtask

  task automatic expect_frame(string req, logic [31:0] a, int l, bit p);
    if (got_addr.size() == 0) begin
      tests++; fails++;
      $display("FAIL %s actual=none expected=%h/%0d", req, a, l);
    end else begin
      check({req, " frame addr"}, got_addr.pop_front(), a);
      check({req, " frame len"}, got_len.pop_front(), l);
      check({req, " padded"}, {31'b0, got_pad.pop_front()}, {31'b0, p});
    end
  endtask

  initial begin
    int wsave;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 cur_desc", cur_desc, 0);
    check("R1 cur_buf", cur_buf, 0);
    check("R1 ev_pend", {29'b0, ev_pend}, 0);
    check("R1 halted", {31'b0, tx_halted}, 0);
    check("R1 irq", {31'b0, tx_irq}, 0);
    check("R1 mem_req", {31'b0, mem_req}, 0);

    // R1 list reset value and R2 enable without poll
    tx_en = 1; repeat (2) @(negedge clk);
    check("R1 list reset via R2 load", cur_desc, 32'hFFFF_FFFC);
    repeat (20) @(negedge clk);
    check("R2 no access before poll", rd_count + wr_count, 0);
    tx_en = 0; @(negedge clk); @(negedge clk);
    check("R12 halted after fall", {31'b0, tx_halted}, 1);
    halt_clr = 1; @(negedge clk); halt_clr = 0; @(negedge clk);
    check("R12 halted cleared", {31'b0, tx_halted}, 0);
    do_poll(20);
    check("R2 poll ignored while off", rd_count + wr_count, 0);

    // main ring: R3 R5 R6 R8 R4 R9
    put_desc(32'h100, OWN | PAD | IEN, 32'h1000, 32'hABCD_0014, 32'h110);
    put_desc(32'h110, OWN | 32'h0F00, 32'h2000, 32'h0000_0064, 32'h120);
    put_desc(32'h120, OWN | PAD, 32'h3000, 32'h1234_003B, 32'h130);
    put_desc(32'h130, 32'h0, 32'h0, 32'h0, 32'h140);
    base_wdata = 32'h100; base_we = 1; @(negedge clk); base_we = 0;
    tx_en = 1; repeat (2) @(negedge clk);
    check("R2 load from list start", cur_desc, 32'h100);
    do_poll(300);
    expect_frame("R5 pad short", 32'h1000, 60, 1);
    expect_frame("R5 no pad", 32'h2000, 100, 0);
    expect_frame("R5 pad 59", 32'h3000, 60, 1);
    check("R6 flags wb 0", mem[32'h100], PAD | IEN);
    check("R6 flags wb 1 keep bits", mem[32'h110], 32'h0F00);
    check("R6 stat wb 0 upper cleared", mem[32'h108], 32'h14 | DONE);
    check("R6 stat wb 1", mem[32'h118], 32'h64 | DONE);
    check("R6 stat wb 2", mem[32'h128], 32'h3B | DONE);
    check("R3 next word untouched", mem[32'h10C], 32'h110);
    check("R8 R4 cur_desc at CPU owned", cur_desc, 32'h130);
    check("R4 no writeback of CPU desc", mem[32'h130], 0);
    check("R7 R4 events", {29'b0, ev_pend}, 3'b011);
    check("R9 cur_buf", cur_buf, 32'h3000);

    // R13 clear, R7 no done without ien, R6 intr bit, R8 resume from cur_desc
    clear_events();
    check("R13 cleared", {29'b0, ev_pend}, 0);
    ev_en = 3'b001;
    put_desc(32'h130, OWN | PAD, 32'h4000, 32'h0000_003C, 32'h140);
    put_desc(32'h140, OWN | IEN, 32'h5000, 32'h0000_000A, 32'h150);
    put_desc(32'h150, 32'h0, 32'h0, 32'h0, 32'h160);
    do_poll(200);
    expect_frame("R5 pad at 60", 32'h4000, 60, 0);
    expect_frame("R5 short no pad", 32'h5000, 10, 0);
    check("R6 R7 stat no intr", mem[32'h138], 32'h3C | DONE);
    check("R6 stat with intr", mem[32'h148], 32'h0A | DONE | INTR);
    check("R7 events", {29'b0, ev_pend}, 3'b011);
    check("R13 irq high", {31'b0, tx_irq}, 1);
    check("R8 cur_desc", cur_desc, 32'h150);
    check("R9 cur_buf", cur_buf, 32'h5000);
    ev_en = 3'b000; @(negedge clk);
    check("R13 irq masked", {31'b0, tx_irq}, 0);

    // R11 buffer error
    clear_events();
    buf_err[32'h6000] = 1;
    put_desc(32'h150, OWN | IEN, 32'h6000, 32'hFFFF_001E, 32'h160);
    mem[32'h160] = 32'h0;
    do_poll(100);
    expect_frame("R11 frame", 32'h6000, 30, 0);
    check("R11 events", {29'b0, ev_pend}, 3'b110);
    check("R11 flags wb", mem[32'h150], IEN);
    check("R11 stat no done", mem[32'h158], 32'h1E);
    check("R11 advanced", cur_desc, 32'h160);

    // R10 descriptor read error
    clear_events();
    err_addr[32'h160] = 1;
    mem[32'h160] = OWN;
    wsave = wr_count;
    do_poll(60);
    check("R10 events", {29'b0, ev_pend}, 3'b100);
    check("R10 cur_desc kept", cur_desc, 32'h160);
    check("R10 no writeback", wr_count, wsave);
    check("R10 no frame", got_addr.size(), 0);

    // R12 set wins over clear, then R2 reload
    tx_en = 0; halt_clr = 1; @(negedge clk); halt_clr = 0; @(negedge clk);
    check("R12 set wins", {31'b0, tx_halted}, 1);
    halt_clr = 1; @(negedge clk); halt_clr = 0; @(negedge clk);
    check("R12 cleared", {31'b0, tx_halted}, 0);
    tx_en = 1; repeat (2) @(negedge clk);
    check("R2 reload on rise", cur_desc, 32'h100);
    tx_en = 0; repeat (3) @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule